// File: doc/BRIEF.md
# Receive Buffer Idle Timeout Detector

This block watches the receive buffer of a serial port and raises a level interrupt when characters have been waiting, unread, for too long. It never sees the serial line or the buffer storage. It sees only the events around the buffer: a pulse for each character stored, a pulse for each processor read, the current occupancy, two enable bits, and a 16x oversample tick from the baud generator.

Idle time is measured in whole character times. The length of one character is worked out from the programmed frame format: one start bit, five to eight data bits, an optional parity bit, and one or two stop bits. The second stop bit is part of the length. The threshold is four character times. Because the timer advances only on the baud tick, the delay scales with the line rate. At 300 baud with a 12-bit frame, the worst case is 160 ms.

The restart rules depend on whether an interrupt is pending:
- While no interrupt is pending, both a new character and a processor read restart the timer.
- Once the interrupt is pending, only a processor read acts: it clears the flag and restarts the timer.

Top module: `rx_idle_timeout`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the idle timer and the interrupt, so `timeout_irq` is 0 during and right after reset.
- R2: `timeout_irq` is 1 only while `fifo_en`, `rx_irq_en` are both 1 and `fifo_count` is nonzero. Dropping any of these forces it to 0 in the same cycle and clears the timer, so a fresh full threshold is needed afterwards.
- R3: The threshold in oversample ticks is 4 × 16 × (1 + (5 + `data_sel`) + `parity_en` + (`two_stop` ? 2 : 1)), where `data_sel` is 0..3 for 5..8 data bits. With a tick on every cycle and the timer restarted at clock edge E0, `timeout_irq` is still 0 after edge E0+L, where L is the threshold, and is 1 after edge E0+L+1.
- R4: Setting `two_stop` lengthens the threshold by 64 ticks; with 8 data bits and no parity the threshold is 704 ticks.
- R5: While no interrupt is pending, an `rx_push` pulse restarts the timer, and `timeout_irq` stays 0 in the cycle after that pulse.
- R6: While no interrupt is pending, a `cpu_pop` pulse restarts the timer, and `timeout_irq` stays 0 in the cycle after that pulse.
- R7: While the interrupt is pending, a `cpu_pop` pulse clears it in the next cycle and restarts the timer.
- R8: While the interrupt is pending, `rx_push` neither clears it nor restarts the timer; `timeout_irq` stays 1 until a read or a disable.
- R9: The timer advances only on cycles where `baud_tick` is 1; without ticks no interrupt is raised however long the buffer sits.
- R10: With `fifo_count` at 0 the timer is held at zero, so after data returns a full threshold must elapse again.
- R11: The threshold follows the data-bit and parity fields: 5 data bits with parity and one stop bit give 512 ticks, and 6 data bits with two stop bits give 576 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | 16x oversample enable from the baud generator |
| data_sel | input | 2 | Data bits minus five (0..3) |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| rx_push | input | 1 | One-cycle pulse per character stored in the buffer |
| cpu_pop | input | 1 | One-cycle pulse per processor read of the buffer |
| fifo_count | input | CNT_W | Current buffer occupancy |
| fifo_en | input | 1 | Buffer mode enabled |
| rx_irq_en | input | 1 | Receive interrupts enabled |
| timeout_irq | output | 1 | Character time-out interrupt, level |

## Verification
Several rules are checked on every cycle:
- The output never stands high while the buffer is empty or either enable is off.
- A push or a read seen while no interrupt is pending keeps the flag low in the next cycle.
- A read while the flag is high drops it in the next cycle.
- A pending flag stays high unless a read or a disable arrives.

The exact threshold per frame format, the extra stop-bit length, and the stall without baud ticks are time-window properties. Only the bench scenarios show those, by counting edges from each restart and sampling just before and just after the expected edge.

// File: rtl/rx_to_pkg.sv
package rx_to_pkg;

    typedef struct packed {
        logic [1:0] data_sel;
        logic       parity_en;
        logic       two_stop;
    } frame_fmt_t;

    // Bits in one serial character: start + data + optional parity + stops.
    function automatic logic [3:0] frame_bits(input frame_fmt_t fmt);
        logic [3:0] n;
        n = 4'd1 + (4'd5 + {2'b00, fmt.data_sel});
        n = n + {3'b000, fmt.parity_en};
        n = n + (fmt.two_stop ? 4'd2 : 4'd1);
        return n;
    endfunction

endpackage

// File: rtl/rx_to_frame_limit.sv
module rx_to_frame_limit
    import rx_to_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int CHAR_TIMES = 4,
    parameter int LIMIT_W    = 10
) (
    input  frame_fmt_t         fmt,
    output logic [LIMIT_W-1:0] limit
);
    localparam int TICKS_PER_BIT = OSR * CHAR_TIMES;

    always_comb begin
        limit = LIMIT_W'(frame_bits(fmt)) * LIMIT_W'(TICKS_PER_BIT);
    end
endmodule

// File: rtl/rx_to_restart_sel.sv
module rx_to_restart_sel (
    input  logic pending,
    input  logic rx_push,
    input  logic cpu_pop,
    output logic restart,
    output logic clear
);
    always_comb begin
        clear   = pending & cpu_pop;
        restart = pending ? cpu_pop : (rx_push | cpu_pop);
    end
endmodule

// File: rtl/rx_to_idle_core.sv
module rx_to_idle_core #(
    parameter int LIMIT_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               tick,
    input  logic               restart,
    input  logic               clear,
    input  logic [LIMIT_W-1:0] limit,
    output logic               pending
);
    typedef struct packed {
        logic [LIMIT_W-1:0] cnt;
        logic               irq;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = '0;
        end else begin
            if (restart) begin
                st_d.cnt = '0;
            end else if (tick && (st_q.cnt < limit)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (clear) begin
                st_d.irq = 1'b0;
            end else if (!st_q.irq && !restart && (st_q.cnt >= limit)) begin
                st_d.irq = 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pending = st_q.irq;
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rx_to_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int CHAR_TIMES = 4,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             baud_tick,
    input  logic [1:0]       data_sel,
    input  logic             parity_en,
    input  logic             two_stop,
    input  logic             rx_push,
    input  logic             cpu_pop,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             fifo_en,
    input  logic             rx_irq_en,
    output logic             timeout_irq
);
    localparam int MAX_BITS  = 12;
    localparam int MAX_LIMIT = MAX_BITS * OSR * CHAR_TIMES;
    localparam int LIMIT_W   = $clog2(MAX_LIMIT + 1);

    frame_fmt_t         fmt;
    logic [LIMIT_W-1:0] limit;
    logic               active;
    logic               pending;
    logic               restart;
    logic               clear;

    always_comb begin
        fmt.data_sel  = data_sel;
        fmt.parity_en = parity_en;
        fmt.two_stop  = two_stop;
        active        = fifo_en & rx_irq_en & (fifo_count != '0);
    end

    rx_to_frame_limit #(
        .OSR        (OSR),
        .CHAR_TIMES (CHAR_TIMES),
        .LIMIT_W    (LIMIT_W)
    ) u_limit (
        .fmt   (fmt),
        .limit (limit)
    );

    rx_to_restart_sel u_sel (
        .pending (pending),
        .rx_push (rx_push),
        .cpu_pop (cpu_pop),
        .restart (restart),
        .clear   (clear)
    );

    rx_to_idle_core #(
        .LIMIT_W (LIMIT_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .tick    (baud_tick),
        .restart (restart),
        .clear   (clear),
        .limit   (limit),
        .pending (pending)
    );

    assign timeout_irq = pending & active;
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_push,
    input logic             cpu_pop,
    input logic [CNT_W-1:0] fifo_count,
    input logic             fifo_en,
    input logic             rx_irq_en,
    input logic             timeout_irq
);
    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        timeout_irq |-> (fifo_en && rx_irq_en && (fifo_count != '0)));

    p_push_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (!timeout_irq && rx_push) |=> !timeout_irq);

    p_pop_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (!timeout_irq && cpu_pop) |=> !timeout_irq);

    p_pop_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (timeout_irq && cpu_pop) |=> !timeout_irq);

    p_pending_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (timeout_irq && !cpu_pop) |=>
            (timeout_irq || !fifo_en || !rx_irq_en || (fifo_count == '0)));
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_push     (rx_push),
    .cpu_pop     (cpu_pop),
    .fifo_count  (fifo_count),
    .fifo_en     (fifo_en),
    .rx_irq_en   (rx_irq_en),
    .timeout_irq (timeout_irq)
);

// File: tb/rx_idle_timeout_test.sv
`timescale 1ns/1ps
module rx_idle_timeout_test;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             baud_tick = 1'b1;
    logic [1:0]       data_sel = 2'd3;
    logic             parity_en = 1'b0;
    logic             two_stop = 1'b0;
    logic             rx_push = 1'b0;
    logic             cpu_pop = 1'b0;
    logic [CNT_W-1:0] fifo_count = '0;
    logic             fifo_en = 1'b1;
    logic             rx_irq_en = 1'b1;
    logic             timeout_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  exp;
        string req;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    rx_idle_timeout #(.CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .baud_tick   (baud_tick),
        .data_sel    (data_sel),
        .parity_en   (parity_en),
        .two_stop    (two_stop),
        .rx_push     (rx_push),
        .cpu_pop     (cpu_pop),
        .fifo_count  (fifo_count),
        .fifo_en     (fifo_en),
        .rx_irq_en   (rx_irq_en),
        .timeout_irq (timeout_irq)
    );

    // Monitor: compares the output against queued expectations away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (timeout_irq !== it.exp) begin
                    fails++;
                    $display("FAIL %s: timeout_irq=%0b expected %0b", it.req, timeout_irq, it.exp);
                end
            end
        end
    end

    function automatic int threshold(input int dsel, input bit par, input bit stop2);
        return 64 * (1 + 5 + dsel + int'(par) + (stop2 ? 2 : 1));
    endfunction

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_irq(input logic v, input string r);
        sb_q.push_back('{exp: v, req: r});
        wait (sb_q.size() == 0);
    endtask

    task automatic pulse_push();
        rx_push = 1'b1;
        step(1);
        rx_push = 1'b0;
    endtask

    task automatic pulse_pop();
        cpu_pop = 1'b1;
        fifo_count = fifo_count - 1'b1;
        step(1);
        cpu_pop = 1'b0;
    endtask

    // Timer restarted at the last edge: low after L edges, high after L+1.
    task automatic window(input int lim, input string r);
        step(lim);
        expect_irq(1'b0, r);
        step(1);
        expect_irq(1'b1, r);
    endtask

    initial begin
        int lim;
        step(3);
        expect_irq(1'b0, "R1");
        rst = 1'b0;
        step(1);
        expect_irq(1'b0, "R1");

        lim = threshold(3, 1'b0, 1'b0);
        // R3: default 8N1 frame
        fifo_count = 5'd12;
        pulse_push();
        window(lim, "R3");

        // R8: push while pending changes nothing
        pulse_push();
        expect_irq(1'b1, "R8");
        step(50);
        expect_irq(1'b1, "R8");

        // R7: read while pending clears and restarts
        pulse_pop();
        expect_irq(1'b0, "R7");
        window(lim, "R7");

        // R6: read while not pending restarts
        pulse_pop();
        step(300);
        pulse_pop();
        expect_irq(1'b0, "R6");
        window(lim, "R6");

        // R5: push while not pending restarts
        pulse_pop();
        step(300);
        pulse_push();
        expect_irq(1'b0, "R5");
        window(lim, "R5");

        // R2: interrupt enable gates and clears
        rx_irq_en = 1'b0;
        expect_irq(1'b0, "R2");
        step(20);
        expect_irq(1'b0, "R2");
        rx_irq_en = 1'b1;
        window(lim, "R2");

        // R2: buffer mode gates and clears
        fifo_en = 1'b0;
        expect_irq(1'b0, "R2");
        step(20);
        fifo_en = 1'b1;
        window(lim, "R2");

        // R10: empty buffer holds timer in reset
        fifo_count = '0;
        expect_irq(1'b0, "R10");
        step(2000);
        expect_irq(1'b0, "R10");
        fifo_count = 5'd4;
        window(lim, "R10");

        // R9: no ticks, no time-out
        pulse_pop();
        baud_tick = 1'b0;
        step(3000);
        expect_irq(1'b0, "R9");
        baud_tick = 1'b1;
        window(lim, "R9");

        // R4: second stop bit lengthens the threshold
        fifo_count = '0;
        step(1);
        two_stop = 1'b1;
        fifo_count = 5'd2;
        window(threshold(3, 1'b0, 1'b1), "R4");

        // R11: 5 data bits with parity, one stop bit
        fifo_count = '0;
        step(1);
        data_sel = 2'd0;
        parity_en = 1'b1;
        two_stop = 1'b0;
        fifo_count = 5'd2;
        window(threshold(0, 1'b1, 1'b0), "R11");

        // R11: 6 data bits, no parity, two stop bits
        fifo_count = '0;
        step(1);
        data_sel = 2'd1;
        parity_en = 1'b0;
        two_stop = 1'b1;
        fifo_count = 5'd2;
        window(threshold(1, 1'b0, 1'b1), "R11");

        // R1: reset mid-pending clears the flag
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        expect_irq(1'b0, "R1");

        step(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: timeout_irq=%0b expected run to complete", timeout_irq);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule